// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits between one processor's memory request stream and its private cache. It keeps the single reservation that backs load-reserved / store-conditional atomics. A load-reserved request reads memory like a plain load. It also arms a reservation flag and records the word address. A store-conditional request is passed on as a write only when the reservation is still armed for exactly that address. In the same cycle the block reports success (0) or failure (1) to the processor.

The cache reports every coherence invalidation of a line that this processor holds. An invalidation that hits the reserved line disarms the reservation, so a store by another processor to that line makes a later store-conditional fail. The parameter `TRACK_ADDR` selects between two variants. With 1, the address is kept and compared at line granularity on invalidations and at word granularity on store-conditionals. With 0, no address is stored and any invalidation disarms the flag. The second variant is only sound when reservations are never nested. The memory behind the block is assumed to answer reads in the same cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset the reservation is disarmed, so a store-conditional issued first fails (sc_fail=1) and causes no write.
- R2: A load-reserved (req_op=2'b10) issues a memory read of req_addr (mem_req=1, mem_we=0) and returns mem_rdata on resp_rdata in the same cycle. It also arms the reservation for req_addr.
- R3: A store-conditional (req_op=2'b11) succeeds when the reservation is armed and, with TRACK_ADDR=1, the recorded word address equals req_addr. On success it drives mem_req=1, mem_we=1, mem_addr=req_addr and mem_wdata=req_wdata, with sc_done=1 and sc_fail=0 in the same cycle.
- R4: A store-conditional that does not succeed drives sc_done=1 and sc_fail=1 and issues no memory access (mem_req=0, mem_we=0).
- R5: Every store-conditional disarms the reservation, whether it succeeds or fails.
- R6: A new load-reserved replaces any earlier reservation, including its address.
- R7: With TRACK_ADDR=1, an invalidation whose line (address bits above LINE_OFF) equals the reserved line disarms the reservation. An invalidation of any other line leaves it armed.
- R8: With TRACK_ADDR=0, any invalidation disarms the reservation. A store-conditional then succeeds whenever the flag is armed, whatever its address.
- R9: An invalidation of the reserved line in the same cycle as a store-conditional makes it fail. An invalidation of the requested line in the same cycle as a load-reserved leaves the reservation disarmed.
- R10: Plain loads (2'b00) and stores (2'b01) pass straight to memory (stores with mem_we=1) and neither arm nor disarm the reservation.
- R11: sc_done is 1 exactly in cycles that carry a store-conditional request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| resp_rdata | output | DATA_W | Read data returned to the processor |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| inv_valid | input | 1 | Coherence invalidation of a held line |
| inv_addr | input | ADDR_W | Address within the invalidated line |
| sc_done | output | 1 | Store-conditional completes this cycle |
| sc_fail | output | 1 | Store-conditional status: 0 success, 1 failure |

## Verification
On every cycle the embedded assertions check several properties. A failed store-conditional never reaches memory, and every store-conditional leaves the flag clear. A load-reserved arms the reservation unless its line is being invalidated. A matching invalidation clears the flag, plain accesses leave the reservation untouched, and status only appears on store-conditional cycles. Some behaviour only the bench's scenarios can show. It sweeps every reservation address against every invalidation address (or none) and every store-conditional address on both variants, and computes success from line and word equality. That sweep, together with directed sequences for overwrite, repeated store-conditionals and same-cycle collisions, covers the end-to-end outcome of request sequences.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_OFF   = 6,
  parameter bit TRACK_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              sc_done,
  output logic              sc_fail
);
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic resv_q;
  logic is_ld, is_st, is_lr, is_sc;
  logic kill_resv, kill_new, addr_ok, sc_ok;

  assign is_ld = req_valid && req_op == 2'b00;
  assign is_st = req_valid && req_op == 2'b01;
  assign is_lr = req_valid && req_op == 2'b10;
  assign is_sc = req_valid && req_op == 2'b11;

  if (TRACK_ADDR) begin : g_track
    logic [ADDR_W-1:0] resv_addr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) resv_addr_q <= '0;
      else if (is_lr) resv_addr_q <= req_addr;
    end
    assign kill_resv = inv_valid &&
      inv_addr[ADDR_W-1 -: LINE_W] == resv_addr_q[ADDR_W-1 -: LINE_W];
    assign kill_new  = inv_valid &&
      inv_addr[ADDR_W-1 -: LINE_W] == req_addr[ADDR_W-1 -: LINE_W];
    assign addr_ok   = resv_addr_q == req_addr;

    // R6
    lr_records_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_lr |=> resv_addr_q == $past(req_addr));
  end else begin : g_flag_only
    assign kill_resv = inv_valid;
    assign kill_new  = inv_valid;
    assign addr_ok   = 1'b1;
  end

  assign sc_ok = is_sc && resv_q && addr_ok && !kill_resv;

  always_ff @(posedge clk) begin
    if (!rst_n)         resv_q <= 1'b0;
    else if (is_lr)     resv_q <= !kill_new;
    else if (is_sc)     resv_q <= 1'b0;
    else if (kill_resv) resv_q <= 1'b0;
  end

  assign mem_req    = is_ld || is_st || is_lr || sc_ok;
  assign mem_we     = is_st || sc_ok;
  assign mem_addr   = req_addr;
  assign mem_wdata  = req_wdata;
  assign resp_rdata = mem_rdata;
  assign sc_done    = is_sc;
  assign sc_fail    = is_sc && !sc_ok;

  // R4
  failed_sc_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && sc_fail) |-> !mem_req && !mem_we);

  // R5
  sc_clears_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> !resv_q);

  // R2
  lr_arms_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lr && !inv_valid) |=> resv_q);

  // R7
  inv_clears_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_resv && !is_lr) |=> !resv_q);

  // R10
  plain_keeps_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_ld || is_st || !req_valid) && !inv_valid) |=> $stable(resv_q));

  // R11
  status_only_on_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> req_valid && req_op == 2'b11);
endmodule

// File: tb/lrsc_monitor_test.sv
`timescale 1ns/1ps
module lrsc_monitor_test;
  localparam int AW = 4, DW = 8, LO = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, inv_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0, inv_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic [DW-1:0] t_rd, t_mrd, s_rd, s_mrd, t_wd, s_wd;
  logic [AW-1:0] t_ma, s_ma;
  logic t_req, t_we, t_done, t_fail, s_req, s_we, s_done, s_fail;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign t_mrd = {~t_ma, t_ma};
  assign s_mrd = {~s_ma, s_ma};

  lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFF(LO), .TRACK_ADDR(1'b1)) uut (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata,
    .resp_rdata(t_rd), .mem_req(t_req), .mem_we(t_we), .mem_addr(t_ma),
    .mem_wdata(t_wd), .mem_rdata(t_mrd), .inv_valid, .inv_addr,
    .sc_done(t_done), .sc_fail(t_fail));

  lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFF(LO), .TRACK_ADDR(1'b0)) uut_flag (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata,
    .resp_rdata(s_rd), .mem_req(s_req), .mem_we(s_we), .mem_addr(s_ma),
    .mem_wdata(s_wd), .mem_rdata(s_mrd), .inv_valid, .inv_addr,
    .sc_done(s_done), .sc_fail(s_fail));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, leave time for combinational outputs to settle
  task automatic drive(input bit v, input logic [1:0] op, input int a, input int wd,
                       input bit iv, input int ia);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = AW'(a); req_wdata = DW'(wd);
    inv_valid = iv; inv_addr = AW'(ia);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 2'b00, 0, 0, 1'b0, 0);
  endtask

  // check a store-conditional outcome on one variant
  task automatic chk_sc(input bit trk, input bit exp_ok, input string tag, input int wd);
    bit done = trk ? t_done : s_done;
    bit fl   = trk ? t_fail : s_fail;
    bit we   = trk ? t_we : s_we;
    bit rq   = trk ? t_req : s_req;
    int wdat = trk ? int'(t_wd) : int'(s_wd);
    chk(done == 1'b1, {tag, " sc_done"}, done, 1);
    chk(fl == !exp_ok, {tag, " sc_fail"}, fl, !exp_ok);
    chk(we == exp_ok && rq == exp_ok, {tag, " write"}, we, exp_ok);
    if (exp_ok) chk(wdat == (wd & 8'hff), {tag, " wdata"}, wdat, wd & 8'hff);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: store-conditional right after reset fails on both variants
    drive(1'b1, 2'b11, 5, 8'h11, 1'b0, 0);
    chk_sc(1'b1, 1'b0, "R1 track", 8'h11);
    chk_sc(1'b0, 1'b0, "R1 flag", 8'h11);

    // R10 and R11: plain accesses pass through, no status
    drive(1'b1, 2'b10, 2, 0, 1'b0, 0);
    drive(1'b1, 2'b01, 2, 8'h5a, 1'b0, 0);
    chk(t_we && t_req && t_wd == 8'h5a && !t_done, "R10 store passthrough", t_we, 1);
    chk(!s_done && !t_fail, "R11 no status on store", t_done, 0);
    drive(1'b1, 2'b00, 9, 0, 1'b0, 0);
    chk(t_req && !t_we && t_rd == {~4'd9, 4'd9}, "R10 load data", t_rd, {~4'd9, 4'd9});
    drive(1'b1, 2'b11, 2, 8'h33, 1'b0, 0);
    chk_sc(1'b1, 1'b1, "R10 resv kept across plain ops", 8'h33);
    chk_sc(1'b0, 1'b1, "R10 resv kept flag variant", 8'h33);

    // R6: later load-reserved replaces earlier one
    drive(1'b1, 2'b10, 3, 0, 1'b0, 0);
    drive(1'b1, 2'b10, 8, 0, 1'b0, 0);
    drive(1'b1, 2'b11, 3, 8'h44, 1'b0, 0);
    chk_sc(1'b1, 1'b0, "R6 old address rejected", 8'h44);
    drive(1'b1, 2'b10, 3, 0, 1'b0, 0);
    drive(1'b1, 2'b10, 8, 0, 1'b0, 0);
    drive(1'b1, 2'b11, 8, 8'h45, 1'b0, 0);
    chk_sc(1'b1, 1'b1, "R6 new address accepted", 8'h45);

    // R5: second store-conditional fails after success and after failure
    drive(1'b1, 2'b10, 5, 0, 1'b0, 0);
    drive(1'b1, 2'b11, 5, 8'h55, 1'b0, 0);
    chk_sc(1'b1, 1'b1, "R5 first sc", 8'h55);
    drive(1'b1, 2'b11, 5, 8'h56, 1'b0, 0);
    chk_sc(1'b1, 1'b0, "R5 repeat after success", 8'h56);
    chk_sc(1'b0, 1'b0, "R5 repeat after success flag", 8'h56);
    drive(1'b1, 2'b10, 5, 0, 1'b0, 0);
    drive(1'b1, 2'b11, 6, 8'h57, 1'b0, 0);
    chk_sc(1'b1, 1'b0, "R5 wrong address", 8'h57);
    drive(1'b1, 2'b11, 5, 8'h58, 1'b0, 0);
    chk_sc(1'b1, 1'b0, "R5 repeat after failure", 8'h58);

    // R9: same-cycle invalidation with store-conditional / load-reserved
    drive(1'b1, 2'b10, 5, 0, 1'b0, 0);
    drive(1'b1, 2'b11, 5, 8'h61, 1'b1, 4);
    chk_sc(1'b1, 1'b0, "R9 inv with sc", 8'h61);
    chk_sc(1'b0, 1'b0, "R9 inv with sc flag", 8'h61);
    drive(1'b1, 2'b10, 10, 0, 1'b1, 11);
    drive(1'b1, 2'b11, 10, 8'h62, 1'b0, 0);
    chk_sc(1'b1, 1'b0, "R9 inv with lr same line", 8'h62);
    drive(1'b1, 2'b10, 10, 0, 1'b1, 12);
    drive(1'b1, 2'b11, 10, 8'h63, 1'b0, 0);
    chk_sc(1'b1, 1'b1, "R9 inv with lr other line", 8'h63);
    chk_sc(1'b0, 1'b0, "R8 inv with lr any line", 8'h63);

    // R2 R3 R4 R7 R8: sweep reservation x invalidation x target addresses
    for (int a = 0; a < 16; a++)
      for (int k = 0; k <= 16; k++)
        for (int b = 0; b < 16; b++) begin
          bit trk_ok, flg_ok;
          int wd = (a * 16 + b + k) & 8'hff;
          drive(1'b1, 2'b10, a, 0, 1'b0, 0);
          if (b == 0) begin
            chk(t_req && !t_we && t_rd == DW'({~a[3:0], a[3:0]}), "R2 lr read track",
                t_rd, {~a[3:0], a[3:0]});
            chk(s_req && !s_we && s_rd == DW'({~a[3:0], a[3:0]}), "R2 lr read flag",
                s_rd, {~a[3:0], a[3:0]});
          end
          if (k < 16) drive(1'b0, 2'b00, 0, 0, 1'b1, k);
          else idle();
          drive(1'b1, 2'b11, b, wd, 1'b0, 0);
          trk_ok = (k == 16 || (k >> LO) != (a >> LO)) && (a == b);
          flg_ok = (k == 16);
          chk_sc(1'b1, trk_ok, trk_ok ? "R3 R7 sweep track" : "R4 R7 sweep track", wd);
          chk_sc(1'b0, flg_ok, flg_ok ? "R3 R8 sweep flag" : "R4 R8 sweep flag", wd);
        end

    idle();
    chk(!t_done && !s_done && !t_fail, "R11 idle no status", t_done, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule